// File: doc/BRIEF.md
# Two-Colour Indicator Blink Controller

This block drives one green and one red indicator from a small set of word-addressed registers. Each colour has a 32-bit on/off pattern word and a step-delay word. When a colour's playback is switched on, its output runs through the pattern one bit at a time, from the top bit down to bit 0, and then starts again. The step rate comes from the delay word, which holds the negative of the number of clock cycles per step. When playback is off, the colour simply shows bit 0 of its pattern word.

A control word sits above both colours. It has per-colour output enables, two playback-enable bits per colour (both must be set), and force-on and force-off overrides. These overrides are resolved in a fixed priority order. Red has one more override whose sense depends on the green force-on bit. Both LED outputs are active-high and registered. They change one clock after the control or pattern state that selects them.

Top module: `led_blink_ctrl`

## Requirements
- R1: After synchronous active-low reset, both LED outputs are 0 and every register reads 0.
- R2: A write stores its data at word address 0 (control, low 14 bits kept, upper bits read 0), 1 (green pattern), 2 (green step delay), 3 (red pattern) or 4 (red step delay). Reads return the stored value combinationally. Addresses 5 to 7 read 0, and writes to them change nothing.
- R3: With green playback off and no green override, the green output equals control bit 0 AND green pattern bit 0.
- R4: With red playback off and no red override, the red output equals control bit 9 AND red pattern bit 0.
- R5: Green playback runs only when control bits 1 and 6 are both 1. Red playback runs only when control bits 10 and 12 are both 1. With only one of the pair set, the output stays static as in R3/R4.
- R6: During playback with a delay word equal to -N (two's complement, N ≥ 1), the output shows pattern bit 31 for N cycles, then bit 30, and so on down to bit 0, and then returns to bit 31. Output is still gated by the colour's enable bit (0 or 9).
- R7: Clearing a playback enable returns that colour to bit 31 and reloads its step counter. Re-enabling restarts the sequence from bit 31.
- R8: Green priority: control bit 2 forces green off, above bit 4 (force green on), above the pattern source.
- R9: Red priority: control bit 3 forces red off, above bit 5 (force red on), above bit 13 (red on when bit 4 is 0, red off when bit 4 is 1), above the pattern source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe for the addressed register |
| bus_addr_i | input | 3 | Word address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| led_green_o | output | 1 | Green indicator, active high |
| led_red_o | output | 1 | Red indicator, active high |

## Verification
Static cases use pattern words whose bit 0 differs from bit 31. This shows whether an output reflects the static source or a playback that was started by mistake, with each enable pair tried half set. Playback is checked with an irregular green pattern through more than one full lap at a four-cycle step. This catches bit-order, step-length and wrap errors. A shorter red run checks a different step length. A second restart after a partial lap shows whether the position really returns to the top bit. The override cases set several control bits at once, one for each pair of neighbours in the priority chains, including red's bit-4-dependent override in both senses.

// File: rtl/led_blink_pkg.sv
// Shared definitions for the two-colour blink controller.
// Assumes word addressing and a 32-bit register bus.
package led_blink_pkg;
    localparam int NUM_COLOURS = 2;
    localparam int CLR_GREEN   = 0;
    localparam int CLR_RED     = 1;
    localparam int CTRL_W      = 14;

    // Word addresses of the register map.
    localparam int ADR_CTRL = 0;
    // Pattern word of colour c sits at 1+2c, its delay word at 2+2c.
    localparam int ADR_COLOUR_BASE = 1;

    // Control bit positions (behaviour depends on them).
    localparam int CB_G_OUT   = 0;
    localparam int CB_G_RUN_A = 1;
    localparam int CB_G_KILL  = 2;
    localparam int CB_R_KILL  = 3;
    localparam int CB_G_FORCE = 4;
    localparam int CB_R_FORCE = 5;
    localparam int CB_G_RUN_B = 6;
    localparam int CB_R_OUT   = 9;
    localparam int CB_R_RUN_A = 10;
    localparam int CB_R_RUN_B = 12;
    localparam int CB_R_ALT   = 13;

    // Decoded view of the control word.
    typedef struct packed {
        logic g_out;
        logic g_run_a;
        logic g_run_b;
        logic g_kill;
        logic g_force;
        logic r_out;
        logic r_run_a;
        logic r_run_b;
        logic r_kill;
        logic r_force;
        logic r_alt;
    } ctrl_t;
endpackage

// File: rtl/led_reg_bank.sv
// Register bank: control word plus a pattern and a step-delay word per colour.
// Assumes single-cycle writes and a combinational read port; unmapped
// addresses read zero and ignore writes.
module led_reg_bank
    import led_blink_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_i,
    input  logic [ADDR_W-1:0]                     addr_i,
    input  logic [DATA_W-1:0]                     wdata_i,
    output logic [DATA_W-1:0]                     rdata_o,
    output ctrl_t                                 ctrl_o,
    output logic [NUM_COLOURS-1:0][DATA_W-1:0]    pat_o,
    output logic [NUM_COLOURS-1:0][DATA_W-1:0]    dly_o
);
    localparam int LAST_ADR = ADR_COLOUR_BASE + 2 * NUM_COLOURS - 1;

    logic [CTRL_W-1:0] ctrl_q;
    logic              ctrl_sel;

    assign ctrl_sel = wr_i && (addr_i == ADDR_W'(ADR_CTRL));

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= '0;
        else if (ctrl_sel) ctrl_q <= wdata_i[CTRL_W-1:0];
    end

    for (genvar c = 0; c < NUM_COLOURS; c++) begin : g_colour
        localparam int PAT_ADR = ADR_COLOUR_BASE + 2 * c;
        localparam int DLY_ADR = PAT_ADR + 1;
        logic [DATA_W-1:0] pat_q;
        logic [DATA_W-1:0] dly_q;

        // Pattern and delay words of this colour.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pat_q <= '0;
                dly_q <= '0;
            end else if (wr_i) begin
                if (addr_i == ADDR_W'(PAT_ADR)) pat_q <= wdata_i;
                if (addr_i == ADDR_W'(DLY_ADR)) dly_q <= wdata_i;
            end
        end

        assign pat_o[c] = pat_q;
        assign dly_o[c] = dly_q;
    end

    // Read multiplexer over the mapped words.
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(ADR_CTRL)) rdata_o = DATA_W'(ctrl_q);
        for (int c = 0; c < NUM_COLOURS; c++) begin
            if (addr_i == ADDR_W'(ADR_COLOUR_BASE + 2 * c))     rdata_o = pat_o[c];
            if (addr_i == ADDR_W'(ADR_COLOUR_BASE + 2 * c + 1)) rdata_o = dly_o[c];
        end
    end

    // Decode control bits into named fields.
    always_comb begin
        ctrl_o.g_out   = ctrl_q[CB_G_OUT];
        ctrl_o.g_run_a = ctrl_q[CB_G_RUN_A];
        ctrl_o.g_run_b = ctrl_q[CB_G_RUN_B];
        ctrl_o.g_kill  = ctrl_q[CB_G_KILL];
        ctrl_o.g_force = ctrl_q[CB_G_FORCE];
        ctrl_o.r_out   = ctrl_q[CB_R_OUT];
        ctrl_o.r_run_a = ctrl_q[CB_R_RUN_A];
        ctrl_o.r_run_b = ctrl_q[CB_R_RUN_B];
        ctrl_o.r_kill  = ctrl_q[CB_R_KILL];
        ctrl_o.r_force = ctrl_q[CB_R_FORCE];
        ctrl_o.r_alt   = ctrl_q[CB_R_ALT];
    end

    // R2: a control write lands on the next edge.
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_sel |=> ctrl_q == $past(wdata_i[CTRL_W-1:0]));
    // R2: without a write strobe the control word holds.
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(ctrl_q));
    // R2: unmapped addresses read zero.
    a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr_i) > LAST_ADR) |-> rdata_o == '0);
endmodule

// File: rtl/led_step_player.sv
// Pattern player for one colour: walks the pattern from the top bit down
// with a step counter loaded from a negative delay and counting up to zero.
// Assumes the delay word is the two's complement of the step length.
module led_step_player #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [DATA_W-1:0] pat_i,
    input  logic [DATA_W-1:0] dly_i,
    output logic              bit_o
);
    localparam int              IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] TOP  = IDX_W'(DATA_W - 1);

    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] cnt_q;
    logic              wrap;

    assign wrap = (cnt_q == '1);

    // Step counter and bit position update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= TOP;
            cnt_q <= '0;
        end else if (!run_i) begin
            idx_q <= TOP;
            cnt_q <= dly_i;
        end else if (wrap) begin
            cnt_q <= dly_i;
            idx_q <= (idx_q == '0) ? TOP : idx_q - 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Source bit: walking position while running, else bit 0.
    assign bit_o = run_i ? pat_i[idx_q] : pat_i[0];

    // R7: an idle player sits at the top bit.
    a_r7_idle_home: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> idx_q == TOP);
    // R6: position holds until the counter reaches zero.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !wrap) |=> $stable(idx_q));
    // R6: one step down per counter wrap.
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && wrap && idx_q != '0) |=> idx_q == $past(idx_q) - 1'b1);
    // R6: bit 0 is followed by the top bit.
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && wrap && idx_q == '0) |=> idx_q == TOP);
endmodule

// File: rtl/led_drive_mux.sv
// Override resolution and output registers for both indicators.
// Assumes source bits are already chosen by the players; outputs are
// active-high and registered.
module led_drive_mux
    import led_blink_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl_i,
    input  logic  g_bit_i,
    input  logic  r_bit_i,
    output logic  led_g_o,
    output logic  led_r_o
);
    logic g_nxt;
    logic r_nxt;

    // Green: kill > force-on > gated pattern.
    always_comb begin
        if (ctrl_i.g_kill)       g_nxt = 1'b0;
        else if (ctrl_i.g_force) g_nxt = 1'b1;
        else                     g_nxt = ctrl_i.g_out & g_bit_i;
    end

    // Red: kill > force-on > alternate (sense from green force bit) > pattern.
    always_comb begin
        if (ctrl_i.r_kill)       r_nxt = 1'b0;
        else if (ctrl_i.r_force) r_nxt = 1'b1;
        else if (ctrl_i.r_alt)   r_nxt = ~ctrl_i.g_force;
        else                     r_nxt = ctrl_i.r_out & r_bit_i;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_g_o <= 1'b0;
            led_r_o <= 1'b0;
        end else begin
            led_g_o <= g_nxt;
            led_r_o <= r_nxt;
        end
    end

    a_r8_green_kill: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i.g_kill |=> !led_g_o);
    a_r8_green_force: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i.g_kill && ctrl_i.g_force) |=> led_g_o);
    a_r9_red_kill: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i.r_kill |=> !led_r_o);
    a_r9_red_alt: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i.r_kill && !ctrl_i.r_force && ctrl_i.r_alt)
            |=> led_r_o == !$past(ctrl_i.g_force));
endmodule

// File: rtl/led_blink_ctrl.sv
// Top of the two-colour blink controller: register bank, one pattern
// player per colour, and the override/output stage.
// Assumes a single clock and synchronous active-low reset.
module led_blink_ctrl
    import led_blink_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              led_green_o,
    output logic              led_red_o
);
    ctrl_t                              ctrl;
    logic [NUM_COLOURS-1:0][DATA_W-1:0] pat;
    logic [NUM_COLOURS-1:0][DATA_W-1:0] dly;
    logic [NUM_COLOURS-1:0]             run;
    logic [NUM_COLOURS-1:0]             src_bit;

    led_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .ctrl_o  (ctrl),
        .pat_o   (pat),
        .dly_o   (dly)
    );

    // Playback needs both enable bits of a colour.
    assign run[CLR_GREEN] = ctrl.g_run_a & ctrl.g_run_b;
    assign run[CLR_RED]   = ctrl.r_run_a & ctrl.r_run_b;

    for (genvar c = 0; c < NUM_COLOURS; c++) begin : g_player
        led_step_player #(.DATA_W(DATA_W)) u_player (
            .clk   (clk),
            .rst_n (rst_n),
            .run_i (run[c]),
            .pat_i (pat[c]),
            .dly_i (dly[c]),
            .bit_o (src_bit[c])
        );
    end

    led_drive_mux u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_i  (ctrl),
        .g_bit_i (src_bit[CLR_GREEN]),
        .r_bit_i (src_bit[CLR_RED]),
        .led_g_o (led_green_o),
        .led_r_o (led_red_o)
    );

    // R3: static green follows enable AND pattern bit 0.
    a_r3_green_static: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[CLR_GREEN] && !ctrl.g_kill && !ctrl.g_force)
            |=> led_green_o == $past(ctrl.g_out & pat[CLR_GREEN][0]));
    // R4: static red follows enable AND pattern bit 0.
    a_r4_red_static: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[CLR_RED] && !ctrl.r_kill && !ctrl.r_force && !ctrl.r_alt)
            |=> led_red_o == $past(ctrl.r_out & pat[CLR_RED][0]));
endmodule

// File: tb/led_blink_ctrl_tb_top.sv
// Self-checking bench for the two-colour blink controller.
module led_blink_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 3;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] gpat;
        logic [31:0] rpat;
        logic        exp_g;
        logic        exp_r;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{32'h0001, 32'h00000001, 32'h0, 1'b1, 1'b0, 4'd3}, // R3 enabled, bit0=1
        '{32'h0001, 32'hFFFFFFFE, 32'h0, 1'b0, 1'b0, 4'd3}, // R3 bit0=0
        '{32'h0000, 32'h00000001, 32'h0, 1'b0, 1'b0, 4'd3}, // R3 disabled
        '{32'h0200, 32'h0, 32'h00000001, 1'b0, 1'b1, 4'd4}, // R4 enabled
        '{32'h0200, 32'h0, 32'h80000000, 1'b0, 1'b0, 4'd4}, // R4 bit31 ignored
        '{32'h0000, 32'h0, 32'h00000001, 1'b0, 1'b0, 4'd4}, // R4 disabled
        '{32'h0003, 32'h00000001, 32'h0, 1'b1, 1'b0, 4'd5}, // R5 only bit1
        '{32'h0041, 32'h00000001, 32'h0, 1'b1, 1'b0, 4'd5}, // R5 only bit6
        '{32'h0600, 32'h0, 32'h00000001, 1'b0, 1'b1, 4'd5}, // R5 only bit10
        '{32'h1200, 32'h0, 32'h00000001, 1'b0, 1'b1, 4'd5}, // R5 only bit12
        '{32'h0014, 32'h00000001, 32'h0, 1'b0, 1'b0, 4'd8}, // R8 kill over force
        '{32'h0010, 32'h0, 32'h0, 1'b1, 1'b0, 4'd8},        // R8 force on
        '{32'h0005, 32'h00000001, 32'h0, 1'b0, 1'b0, 4'd8}, // R8 kill over pattern
        '{32'h0228, 32'h0, 32'h00000001, 1'b0, 1'b0, 4'd9}, // R9 kill over force
        '{32'h0020, 32'h0, 32'h0, 1'b0, 1'b1, 4'd9},        // R9 force on
        '{32'h2000, 32'h0, 32'h0, 1'b0, 1'b1, 4'd9},        // R9 alt, bit4=0 -> on
        '{32'h2010, 32'h0, 32'h0, 1'b1, 1'b0, 4'd9},        // R9 alt, bit4=1 -> off
        '{32'h2208, 32'h0, 32'h00000001, 1'b0, 1'b0, 4'd9}, // R9 kill over alt
        '{32'h2210, 32'h0, 32'h00000001, 1'b1, 1'b0, 4'd9}, // R9 alt over pattern
        '{32'h2030, 32'h0, 32'h0, 1'b1, 1'b1, 4'd9}         // R9 force over alt
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          led_g;
    logic          led_r;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    led_blink_ctrl #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .led_green_o (led_g),
        .led_red_o   (led_r)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    task automatic settle2;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] rv;
        logic [31:0] gp;
        logic [31:0] rp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 green", 32'(led_g), 32'd0);
        check("R1 red", 32'(led_r), 32'd0);
        for (int a = 0; a < 5; a++) begin
            rd(a, rv);
            check("R1 reg", rv, 32'd0);
        end

        // R2: readback and unmapped addresses
        wr(1, 32'hDEADBEEF); wr(2, 32'h12345678); wr(3, 32'hCAFEF00D); wr(4, 32'h0BADF00D);
        wr(0, 32'hFFFF_0000);
        rd(0, rv); check("R2 ctrl", rv, 32'h0000_0000);
        wr(0, 32'h0000_C000);
        rd(0, rv); check("R2 ctrl14", rv, 32'h0000_0000);
        rd(1, rv); check("R2 gpat", rv, 32'hDEADBEEF);
        rd(2, rv); check("R2 gdly", rv, 32'h12345678);
        rd(3, rv); check("R2 rpat", rv, 32'hCAFEF00D);
        rd(4, rv); check("R2 rdly", rv, 32'h0BADF00D);
        wr(5, 32'h1111_1111); wr(6, 32'h2222_2222); wr(7, 32'h3333_3333);
        for (int a = 5; a < 8; a++) begin
            rd(a, rv); check("R2 unmapped", rv, 32'd0);
        end
        rd(0, rv); check("R2 unmapped no effect ctrl", rv, 32'd0);
        rd(1, rv); check("R2 unmapped no effect gpat", rv, 32'hDEADBEEF);
        wr(0, 32'h0000_2A5C);
        rd(0, rv); check("R2 ctrl value", rv, 32'h0000_2A5C);
        for (int a = 0; a < 5; a++) wr(a, 32'd0);

        // Static and override vectors (R3 R4 R5 R8 R9)
        for (int i = 0; i < NV; i++) begin
            wr(1, TBL[i].gpat);
            wr(3, TBL[i].rpat);
            wr(0, TBL[i].ctrl);
            settle2();
            check($sformatf("R%0d vec%0d green", TBL[i].req, i), 32'(led_g), 32'(TBL[i].exp_g));
            check($sformatf("R%0d vec%0d red", TBL[i].req, i), 32'(led_r), 32'(TBL[i].exp_r));
        end

        // R6: green playback, step of 4 cycles, more than one lap
        gp = 32'hA5C3_0F96;
        wr(0, 32'h0);
        wr(1, gp);
        wr(2, 32'hFFFF_FFFC);
        wr(0, 32'h0043);
        settle2();
        check("R6 green step0", 32'(led_g), 32'(gp[31]));
        for (int k = 1; k < 34; k++) begin
            repeat (4) @(posedge clk);
            @(negedge clk);
            check($sformatf("R6 green step%0d", k), 32'(led_g), 32'(gp[(31 - k) & 31]));
        end

        // R7: clearing one enable goes static, re-enabling restarts at bit 31
        wr(0, 32'h0003);
        settle2();
        check("R7 static after stop", 32'(led_g), 32'(gp[0]));
        wr(0, 32'h0043);
        settle2();
        check("R7 restart bit31", 32'(led_g), 32'(gp[31]));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R7 restart bit30", 32'(led_g), 32'(gp[30]));

        // R6: enable bit gates playback output
        wr(0, 32'h0042);
        settle2();
        check("R6 gated off", 32'(led_g), 32'd0);
        wr(0, 32'h0);

        // R6: red playback, step of 3 cycles
        rp = 32'h6000_0001;
        wr(3, rp);
        wr(4, 32'hFFFF_FFFD);
        wr(0, 32'h1600);
        settle2();
        check("R6 red step0", 32'(led_r), 32'(rp[31]));
        for (int k = 1; k < 6; k++) begin
            repeat (3) @(posedge clk);
            @(negedge clk);
            check($sformatf("R6 red step%0d", k), 32'(led_r), 32'(rp[31 - k]));
        end
        check("R6 green idle during red", 32'(led_g), 32'd0);

        // R1: reset mid-playback clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 red after reset", 32'(led_r), 32'd0);
        rd(3, rv); check("R1 rpat after reset", rv, 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all R): actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule